// File: doc/BRIEF.md
# Serial Pattern Detector with Permanent Lockout

This block watches a serial bit stream, taking one bit per rising clock edge, and raises a one-bit flag whenever the three most recent bits, oldest first, are 0, 1, 0. Matches may overlap, so a stream such as 0,1,0,1,0 flags twice. A second pattern acts as a kill switch. Once the bits 1, 0, 0 have arrived in that order at any point since reset, the detector enters a trapping state and the flag stays low until the next reset.

The controller is a minimised Moore machine with seven states. States are shared wherever the histories of the two patterns overlap, so a "...10" history that continues with a 1 re-enters the "...01" state. The flag is decoded from the next state and held in its own flip-flop. It therefore changes in the same cycle as the state and depends on no input path. A parameter selects either a dense three-bit state encoding or a one-hot encoding. Both encodings must behave identically at the ports.

Top module: `pat_lock_det`

## Requirements
- R1: While `rst` is high at a rising edge, the machine returns to its initial state with no bit history. `hit` is 0 in the cycle after that edge, and bits sampled before the reset never contribute to a later match.
- R2: When the last three bits sampled since reset are 0,1,0 (oldest first) and no lockout is in force, `hit` is 1 in the cycle after the edge that samples the final 0. In every other case `hit` is 0.
- R3: Matches overlap. The stream 0,1,0,1,0 produces `hit` = 0,0,1,0,1.
- R4: Once the bits 1,0,0 have been sampled in that order since reset, `hit` stays 0 for every later bit until reset.
- R5: A 0 that arrives directly after a completed 0,1,0 forms 1,0,0 and starts the lockout. The stream 0,1,0,0,0,1,0 produces `hit` = 0,0,1,0,0,0,0.
- R6: A 1,0 history followed by 1 can still begin a match. The stream 1,0,1,0 produces `hit` = 0,0,0,1.
- R7: The stream 0,0,1,0,1,0,1,0,0,1,0 yields `hit` 0,0,0,1,0,1,0,1,0,0,0. The stream 1,1,0,1,1,0,1,0,0,1,0 yields `hit` 0,0,0,0,0,0,0,1,0,0,0.
- R8: `hit` is never 1 before three bits have been sampled since reset.
- R9: Reset clears the lockout. After 1,0,0 and a reset, the stream 0,1,0 again produces a match on its third bit.
- R10: The dense encoding (`ONE_HOT`=0) and the one-hot encoding (`ONE_HOT`=1) produce identical `hit` sequences for every input stream. In the one-hot variant exactly one state bit is set at all times after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one input bit is sampled per edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| hit | output | 1 | Registered match flag (Moore output) |

## Verification
The bench builds two copies of the block side by side, one with `ONE_HOT`=0 and one with `ONE_HOT`=1, and drives both with the same stimulus. It sweeps every input stream of one to ten bits from reset and checks each output bit against a model built from a three-bit history and a sticky lockout flag. With ten-bit streams every path through the seven states is reached, including lockout entered from each state that can lead into it and overlapping matches both before and after lockout. Directed streams cover the fixed examples, a reset that lands mid-history, and a reset that releases the lockout.

// File: rtl/pat_lock_pkg.sv
package pat_lock_pkg;

  // History classes of the minimised machine; the numeric codes are the
  // dense encoding and the bit index in the one-hot encoding.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // nothing useful seen yet
    ST_Z    = 3'd1,  // ...0
    ST_ZO   = 3'd2,  // ...01
    ST_ZOZ  = 3'd3,  // ...010 (flag state)
    ST_O    = 3'd4,  // ...1
    ST_OZ   = 3'd5,  // ...10
    ST_LOCK = 3'd6   // 100 seen: absorbing
  } pl_state_e;

  localparam int NUM_STATES = 7;
  localparam int CODE_W     = 3;

endpackage

// File: rtl/pat_lock_next.sv
module pat_lock_next
  import pat_lock_pkg::*;
(
  input  pl_state_e cur,
  input  logic      din,
  output pl_state_e nxt
);

  always_comb begin
    unique case (cur)
      ST_IDLE: nxt = din ? ST_O  : ST_Z;
      ST_Z:    nxt = din ? ST_ZO : ST_Z;
      ST_ZO:   nxt = din ? ST_O  : ST_ZOZ;
      ST_ZOZ:  nxt = din ? ST_ZO : ST_LOCK;
      ST_O:    nxt = din ? ST_O  : ST_OZ;
      ST_OZ:   nxt = din ? ST_ZO : ST_LOCK;
      ST_LOCK: nxt = ST_LOCK;
      default: nxt = ST_IDLE;  // unused code falls back to the start
    endcase
  end

endmodule

// File: rtl/pat_lock_state.sv
module pat_lock_state
  import pat_lock_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  pl_state_e nxt,
  output pl_state_e cur
);

  generate
    if (ONE_HOT) begin : g_hot
      logic [NUM_STATES-1:0] hot_q;
      logic [NUM_STATES-1:0] hot_d;
      pl_state_e             cur_c;

      always_comb begin
        for (int i = 0; i < NUM_STATES; i++) begin
          hot_d[i] = (nxt == pl_state_e'(CODE_W'(i)));
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          hot_q <= NUM_STATES'(1) << ST_IDLE;
        end else begin
          hot_q <= hot_d;
        end
      end

      // Any pattern that is not exactly one bit decodes to the start state.
      always_comb begin
        cur_c = ST_IDLE;
        if ($countones(hot_q) == 1) begin
          for (int i = 0; i < NUM_STATES; i++) begin
            if (hot_q[i]) cur_c = pl_state_e'(CODE_W'(i));
          end
        end
      end
      assign cur = cur_c;

      a_r10_single_hot: assert property (@(posedge clk) disable iff (rst)
        $countones(hot_q) == 1)
        else $error("one-hot state register lost its single set bit");
    end else begin : g_dense
      pl_state_e st_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          st_q <= ST_IDLE;
        end else begin
          st_q <= nxt;
        end
      end
      assign cur = st_q;
    end
  endgenerate

endmodule

// File: rtl/pat_lock_out.sv
module pat_lock_out
  import pat_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pl_state_e nxt,
  output logic      hit
);

  // Moore flag registered from the next state so it lines up with the
  // state register and leaves the port straight from a flip-flop.
  always_ff @(posedge clk) begin
    if (rst) begin
      hit <= 1'b0;
    end else begin
      hit <= (nxt == ST_ZOZ);
    end
  end

  a_r1_flag_low_after_reset: assert property (@(posedge clk)
    rst |=> !hit)
    else $error("flag high in the cycle after reset");

endmodule

// File: rtl/pat_lock_det.sv
module pat_lock_det
  import pat_lock_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);

  pl_state_e cur;
  pl_state_e nxt;

  pat_lock_next u_next (
    .cur (cur),
    .din (din),
    .nxt (nxt)
  );

  pat_lock_state #(
    .ONE_HOT (ONE_HOT)
  ) u_state (
    .clk (clk),
    .rst (rst),
    .nxt (nxt),
    .cur (cur)
  );

  pat_lock_out u_out (
    .clk (clk),
    .rst (rst),
    .nxt (nxt),
    .hit (hit)
  );

  // R2: a raised flag implies the three bits before it were 0,1,0.
  a_r2_flag_needs_pattern: assert property (@(posedge clk) disable iff (rst)
    hit |-> (!$past(din, 1) && $past(din, 2) && !$past(din, 3)))
    else $error("flag raised without a 0,1,0 history");

  a_r4_lock_absorbs: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_LOCK) |=> (cur == ST_LOCK))
    else $error("lockout state was left without reset");

  a_r4_lock_silent: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_LOCK) |-> !hit)
    else $error("flag high during lockout");

  a_r5_zero_after_match_locks: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_ZOZ && !din) |=> (cur == ST_LOCK))
    else $error("0 after a match did not lock");

  a_r3_overlap_reenters: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_ZOZ && din) |=> (cur == ST_ZO))
    else $error("1 after a match did not resume the 01 history");

  a_r6_prefix_reuse: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_OZ && din) |=> (cur == ST_ZO))
    else $error("101 history not treated as a match prefix");

  a_r2_flag_tracks_state: assert property (@(posedge clk) disable iff (rst)
    hit == (cur == ST_ZOZ))
    else $error("flag disagrees with the present state");

endmodule

// File: tb/test_pat_lock_det.sv
`timescale 1ns/1ps
module test_pat_lock_det;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit_d;
  logic hit_h;
  int   total = 0;
  int   bad   = 0;

  always #5 clk = ~clk;

  pat_lock_det #(.ONE_HOT(1'b0)) i_pat_lock_det (
    .clk (clk), .rst (rst), .din (din), .hit (hit_d)
  );

  pat_lock_det #(.ONE_HOT(1'b1)) i_pat_lock_det_hot (
    .clk (clk), .rst (rst), .din (din), .hit (hit_h)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: hit=%b expected=%b", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic do_reset();
    rst = 1'b1;
    din = 1'b0;
    @(negedge clk);
    chk("R1 dense", hit_d, 1'b0);
    chk("R1 hot", hit_h, 1'b0);
    rst = 1'b0;
  endtask

  task automatic step(input logic b);
    din = b;
    @(negedge clk);
  endtask

  // Bits and expected flags are written oldest bit at the left.
  task automatic run_seq(input string req, input logic [15:0] bits,
                         input int len, input logic [15:0] exp_z);
    do_reset();
    for (int k = len - 1; k >= 0; k--) begin
      step(bits[k]);
      chk({req, " dense"}, hit_d, exp_z[k]);
      chk({req, " hot"}, hit_h, exp_z[k]);
    end
  endtask

  initial begin
    @(negedge clk);

    // Directed streams
    run_seq("R7", 16'b00101010010, 11, 16'b00010101000);
    run_seq("R7", 16'b11011010010, 11, 16'b00000001000);
    run_seq("R3", 16'b01010, 5, 16'b00101);
    run_seq("R5", 16'b0100010, 7, 16'b0010000);
    run_seq("R6", 16'b1010, 4, 16'b0001);
    run_seq("R4", 16'b1000101010, 10, 16'b0000000000);
    run_seq("R9", 16'b100, 3, 16'b000);
    run_seq("R9", 16'b010, 3, 16'b001);

    // R1: reset landing mid-history drops the 0,1 already seen
    do_reset();
    step(1'b0);
    step(1'b1);
    do_reset();
    step(1'b0);
    chk("R1 history dense", hit_d, 1'b0);
    chk("R1 history hot", hit_h, 1'b0);
    step(1'b1);
    step(1'b0);
    chk("R1 fresh match dense", hit_d, 1'b1);
    chk("R1 fresh match hot", hit_h, 1'b1);

    // Exhaustive sweep of every stream of 1..10 bits from reset
    for (int len = 1; len <= 10; len++) begin
      for (int p = 0; p < (1 << len); p++) begin
        logic [2:0] hist;
        int         cnt;
        logic       lock;
        logic       exp;
        string      tag;
        hist = 3'b000;
        cnt  = 0;
        lock = 1'b0;
        do_reset();
        for (int k = 0; k < len; k++) begin
          logic b;
          b    = p[k];
          hist = {hist[1:0], b};
          cnt++;
          if (cnt >= 3 && hist == 3'b100) lock = 1'b1;
          exp = !lock && cnt >= 3 && hist == 3'b010;
          step(b);
          if (lock)         tag = "R4 sweep";
          else if (cnt < 3) tag = "R8 sweep";
          else              tag = "R2 sweep";
          chk(tag, hit_d, exp);
          chk(tag, hit_h, exp);
          chk("R10 encodings agree", hit_h, hit_d);
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule